// File: doc/BRIEF.md
# Daisy-Chained Probe and Control Register Core

This core hangs on a pass-through register bus with a 16-bit address and 16-bit data. Every field of the upstream bus is address, write data, read data, direction flag (`rw`) and a strobe (`valid`). Each field is captured on every clock edge and presented to the next core downstream, so a chain of such cores forms a pipeline. Each core adds one cycle. Only when a strobed access lands inside this core's own address window does the core act. On a read it replaces the travelling read word with one of its port values. On a write it loads one of its control outputs.

The core owns two groups of ports. The probe inputs have configurable widths and are read-only. The control outputs have configurable widths and can be written and read back. Every port occupies one word address. The probes come first, starting at `BASE_ADDR`, in parameter order. The control outputs follow them. Each strobed cycle is sorted into one of five access classes: `ACC_NONE` (no strobe, or outside the window), `ACC_RD_PROBE`, `ACC_RD_CTRL`, `ACC_WR_CTRL` and `ACC_WR_PROBE`. The class alone decides what the downstream read word carries and which control register, if any, is loaded. The core has no reset input. Its registers start from zero at power-up.

Top module: `chain_io_regs`

## Requirements
- R1: Each clock edge copies `up_addr`, `up_wdata`, `up_rw` and `up_valid` to `dn_addr`, `dn_wdata`, `dn_rw` and `dn_valid`, so each field appears downstream exactly one cycle after it is presented upstream.
- R2: Probe port k (k counted from 0, in parameter order) sits at word address `BASE_ADDR + k`. Control port j sits at `BASE_ADDR + NUM_IN + j`.
- R3: An access is claimed only when `up_valid` is 1 and the address lies between `BASE_ADDR` and `BASE_ADDR + NUM_IN + NUM_OUT - 1`, with both ends included. For every other cycle, `dn_rdata` equals the previous cycle's `up_rdata`.
- R4: A claimed read (`up_rw` = 0) at a probe address makes `dn_rdata` carry the probe's level at that edge, zero-extended to 16 bits.
- R5: A claimed read at a control address returns that control output's current value, zero-extended to 16 bits.
- R6: A claimed write (`up_rw` = 1) at a control address loads the low `width` bits of `up_wdata` into that output. The change is visible from the same edge onward. The higher write bits are dropped, and `dn_rdata` still passes `up_rdata` through.
- R7: A claimed write at a probe address changes no control output, and `dn_rdata` passes `up_rdata` through.
- R8: While `up_valid` is 0, no control output changes, even when the address and `rw` would select one.
- R9: At power-up, before any clock edge, all control outputs and all downstream bus fields are zero. No reset signal is involved.
- R10: Each port is 1 to 16 bits wide. Widths are packed 8 bits per port, with port 0 in the lowest byte. There is at least one probe and at least one control port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| up_addr | input | 16 | Upstream word address |
| up_wdata | input | 16 | Upstream write data |
| up_rdata | input | 16 | Upstream read word travelling down the chain |
| up_rw | input | 1 | 1 = write, 0 = read |
| up_valid | input | 1 | Upstream access strobe |
| probe_in | input | IN_TOTAL | Probe inputs packed with port 0 in the LSBs |
| dn_addr | output | 16 | Registered address to next core |
| dn_wdata | output | 16 | Registered write data to next core |
| dn_rdata | output | 16 | Registered read word, replaced on a read hit |
| dn_rw | output | 1 | Registered direction flag |
| dn_valid | output | 1 | Registered strobe |
| ctrl_out | output | OUT_TOTAL | Control outputs packed with port 0 in the LSBs |

## Verification
A mistake in the access class or the port index shows up one cycle after the access. Either the wrong word appears on `dn_rdata`, or the wrong bits of `ctrl_out` move. Misclassifying a pass-through cycle corrupts the travelling read word. A write decoded against a probe address, or with the strobe low, disturbs `ctrl_out` at the very next edge. The bench therefore checks `ctrl_out` and every downstream field after each access, including cycles that should change nothing. A wrong offset in the width packing shows up as a read-back of a neighbouring port's bits.

// File: rtl/chain_io_pkg.sv
package chain_io_pkg;

    localparam int BUS_W    = 16;
    localparam int FIELD_W  = 8;
    localparam int MAX_LIST = 32;

    typedef logic [BUS_W-1:0]            word_t;
    typedef logic [FIELD_W*MAX_LIST-1:0] list_t;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_RD_PROBE,
        ACC_RD_CTRL,
        ACC_WR_CTRL,
        ACC_WR_PROBE
    } acc_kind_e;

    // width of entry k of a packed width list
    function automatic int width_at(input list_t list, input int k);
        return int'(list[FIELD_W*k +: FIELD_W]);
    endfunction

    // sum of the first count entries: total width, or bit offset of entry count
    function automatic int width_sum(input list_t list, input int count);
        int s;
        s = 0;
        for (int k = 0; k < count; k++) begin
            s = s + width_at(list, k);
        end
        return s;
    endfunction

endpackage

// File: rtl/chain_io_decode.sv
module chain_io_decode
    import chain_io_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h0000,
    parameter int          NUM_IN    = 4,
    parameter int          NUM_PORTS = 8,
    parameter int          IDX_W     = 3
) (
    input  word_t            addr,
    input  logic             valid,
    input  logic             rw,
    output acc_kind_e        kind,
    output logic [IDX_W-1:0] idx
);

    logic [BUS_W:0] rel;
    logic           in_win;
    logic           is_probe;

    always_comb begin
        rel      = {1'b0, addr} - {1'b0, BASE_ADDR};
        in_win   = valid && (addr >= BASE_ADDR) && (rel < (BUS_W+1)'(NUM_PORTS));
        idx      = rel[IDX_W-1:0];
        is_probe = (idx < IDX_W'(NUM_IN));
        if (!in_win) begin
            kind = ACC_NONE;
        end else if (rw) begin
            kind = is_probe ? ACC_WR_PROBE : ACC_WR_CTRL;
        end else begin
            kind = is_probe ? ACC_RD_PROBE : ACC_RD_CTRL;
        end
    end

endmodule

// File: rtl/chain_io_outreg.sv
module chain_io_outreg
    import chain_io_pkg::*;
#(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         armed,
    input  logic         wr_en,
    input  word_t        wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] q_r = '0;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            q_r <= wdata[W-1:0];
        end
    end

    assign q = q_r;

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!armed)
        !wr_en |=> $stable(q)); // R8

endmodule

// File: rtl/chain_io_regs.sv
module chain_io_regs
    import chain_io_pkg::*;
#(
    parameter logic [15:0]         BASE_ADDR  = 16'h0000,
    parameter int                  NUM_IN     = 4,
    parameter int                  NUM_OUT    = 4,
    parameter logic [8*NUM_IN-1:0] IN_WIDTHS  = {8'd1, 8'd10, 8'd7, 8'd1},
    parameter logic [8*NUM_OUT-1:0] OUT_WIDTHS = {8'd1, 8'd1, 8'd3, 8'd5},
    localparam int IN_TOTAL  = chain_io_pkg::width_sum(chain_io_pkg::list_t'(IN_WIDTHS), NUM_IN),
    localparam int OUT_TOTAL = chain_io_pkg::width_sum(chain_io_pkg::list_t'(OUT_WIDTHS), NUM_OUT)
) (
    input  logic                 clk,
    input  logic [15:0]          up_addr,
    input  logic [15:0]          up_wdata,
    input  logic [15:0]          up_rdata,
    input  logic                 up_rw,
    input  logic                 up_valid,
    input  logic [IN_TOTAL-1:0]  probe_in,
    output logic [15:0]          dn_addr,
    output logic [15:0]          dn_wdata,
    output logic [15:0]          dn_rdata,
    output logic                 dn_rw,
    output logic                 dn_valid,
    output logic [OUT_TOTAL-1:0] ctrl_out
);

    localparam int    NUM_PORTS = NUM_IN + NUM_OUT;
    localparam int    IDX_W     = (NUM_PORTS > 2) ? $clog2(NUM_PORTS) : 1;
    localparam list_t IN_LIST   = list_t'(IN_WIDTHS);
    localparam list_t OUT_LIST  = list_t'(OUT_WIDTHS);
    localparam int    OW0       = width_at(OUT_LIST, 0);

    // goes high after the first edge; gates the clocked checks
    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        armed <= 1'b1;
    end

    acc_kind_e          kind;
    logic [IDX_W-1:0]   idx;
    word_t              probe_word [NUM_IN];
    word_t              ctrl_word  [NUM_OUT];
    logic [NUM_OUT-1:0] wr_en;
    word_t              rd_word;

    chain_io_decode #(
        .BASE_ADDR (BASE_ADDR),
        .NUM_IN    (NUM_IN),
        .NUM_PORTS (NUM_PORTS),
        .IDX_W     (IDX_W)
    ) u_decode (
        .addr  (up_addr),
        .valid (up_valid),
        .rw    (up_rw),
        .kind  (kind),
        .idx   (idx)
    );

    // probe ports: slice, zero-extend
    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_probe
        localparam int OFF = width_sum(IN_LIST, gi);
        localparam int W   = width_at(IN_LIST, gi);
        assign probe_word[gi] = word_t'(probe_in[OFF +: W]);
    end

    // control ports: one register each
    for (genvar go = 0; go < NUM_OUT; go++) begin : g_ctrl
        localparam int OFF = width_sum(OUT_LIST, go);
        localparam int W   = width_at(OUT_LIST, go);
        logic [W-1:0] q_w;

        assign wr_en[go] = (kind == ACC_WR_CTRL) && (idx == IDX_W'(NUM_IN + go));

        chain_io_outreg #(.W(W)) u_reg (
            .clk   (clk),
            .armed (armed),
            .wr_en (wr_en[go]),
            .wdata (up_wdata),
            .q     (q_w)
        );

        assign ctrl_out[OFF +: W] = q_w;
        assign ctrl_word[go]      = word_t'(q_w);
    end

    // read word selected by port index
    always_comb begin
        rd_word = '0;
        for (int k = 0; k < NUM_IN; k++) begin
            if (idx == IDX_W'(k)) rd_word = probe_word[k];
        end
        for (int k = 0; k < NUM_OUT; k++) begin
            if (idx == IDX_W'(NUM_IN + k)) rd_word = ctrl_word[k];
        end
    end

    // downstream bus stage
    logic [15:0] addr_q  = '0;
    logic [15:0] wdata_q = '0;
    logic [15:0] rdata_q = '0;
    logic        rw_q    = 1'b0;
    logic        valid_q = 1'b0;

    always_ff @(posedge clk) begin
        addr_q  <= up_addr;
        wdata_q <= up_wdata;
        rw_q    <= up_rw;
        valid_q <= up_valid;
        unique case (kind)
            ACC_RD_PROBE, ACC_RD_CTRL:             rdata_q <= rd_word;
            ACC_NONE, ACC_WR_CTRL, ACC_WR_PROBE:   rdata_q <= up_rdata;
            default:                               rdata_q <= up_rdata;
        endcase
    end

    assign dn_addr  = addr_q;
    assign dn_wdata = wdata_q;
    assign dn_rdata = rdata_q;
    assign dn_rw    = rw_q;
    assign dn_valid = valid_q;

    initial begin
        for (int k = 0; k < NUM_IN; k++) begin
            AST_IN_WIDTH: assert (width_at(IN_LIST, k) >= 1 && width_at(IN_LIST, k) <= 16); // R10
        end
        for (int k = 0; k < NUM_OUT; k++) begin
            AST_OUT_WIDTH: assert (width_at(OUT_LIST, k) >= 1 && width_at(OUT_LIST, k) <= 16); // R10
        end
    end

    AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!armed)
        up_valid |=> dn_valid); // R1
    AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (!armed)
        !up_valid |=> !dn_valid); // R1
    AST_MISS_PASSES: assert property (@(posedge clk) disable iff (!armed)
        (kind == ACC_NONE) |=> (dn_rdata == $past(up_rdata))); // R3
    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!armed)
        $onehot0(wr_en)); // R6
    AST_FIRST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!armed)
        (up_valid && up_rw && up_addr == 16'(BASE_ADDR + NUM_IN))
        |=> (ctrl_out[OW0-1:0] == $past(up_wdata[OW0-1:0]))); // R6
    AST_PROBE_WRITE_INERT: assert property (@(posedge clk) disable iff (!armed)
        (kind == ACC_WR_PROBE) |=> $stable(ctrl_out)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!armed)
        !up_valid |=> $stable(ctrl_out)); // R8

endmodule

// File: tb/chain_io_regs_test.sv
module chain_io_regs_test;

    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] BASE       = 16'h0120;
    localparam int          NV         = 20;

    logic        clk = 1'b0;
    logic [15:0] up_addr  = '0;
    logic [15:0] up_wdata = '0;
    logic [15:0] up_rdata = '0;
    logic        up_rw    = 1'b0;
    logic        up_valid = 1'b0;
    logic [18:0] probe_in = '0;
    logic [15:0] dn_addr, dn_wdata, dn_rdata;
    logic        dn_rw, dn_valid;
    logic [9:0]  ctrl_out;

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 0;

    chain_io_regs #(.BASE_ADDR(BASE)) uut (
        .clk(clk), .up_addr(up_addr), .up_wdata(up_wdata), .up_rdata(up_rdata),
        .up_rw(up_rw), .up_valid(up_valid), .probe_in(probe_in),
        .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata),
        .dn_rw(dn_rw), .dn_valid(dn_valid), .ctrl_out(ctrl_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {valid, rw, addr, wdata, rdata_in, rdata_expected, ctrl_expected}
    // ports: probes p0..p3 at 0x120..0x123 (1,7,10,1 bits)
    // controls c0..c3 at 0x124..0x127 (5,3,1,1 bits), ctrl_out = {c3,c2,c1[2:0],c0[4:0]}
    localparam logic [75:0] VEC [NV] = '{
        {1'b1, 1'b1, 16'h0124, 16'hFFF3, 16'hAAAA, 16'hAAAA, 10'h013}, // R6 c0, upper bits dropped
        {1'b1, 1'b1, 16'h0125, 16'hFFFE, 16'hAAAA, 16'hAAAA, 10'h0D3}, // R6 c1
        {1'b1, 1'b1, 16'h0126, 16'h0001, 16'hAAAA, 16'hAAAA, 10'h1D3}, // R6 c2
        {1'b1, 1'b1, 16'h0127, 16'hFFFF, 16'hAAAA, 16'hAAAA, 10'h3D3}, // R6 c3 at window top
        {1'b1, 1'b0, 16'h0124, 16'h0000, 16'h5555, 16'h0013, 10'h3D3}, // R5 read c0
        {1'b1, 1'b0, 16'h0125, 16'h0000, 16'h5555, 16'h0006, 10'h3D3}, // R5 read c1
        {1'b1, 1'b0, 16'h0126, 16'h0000, 16'h5555, 16'h0001, 10'h3D3}, // R5 read c2
        {1'b1, 1'b0, 16'h0127, 16'h0000, 16'h5555, 16'h0001, 10'h3D3}, // R5 read c3
        {1'b1, 1'b0, 16'h0120, 16'h0000, 16'hFFFF, 16'h0001, 10'h3D3}, // R4 R2 p0 at window bottom
        {1'b1, 1'b0, 16'h0121, 16'h0000, 16'hFFFF, 16'h005A, 10'h3D3}, // R4 R2 p1
        {1'b1, 1'b0, 16'h0122, 16'h0000, 16'hFFFF, 16'h02C3, 10'h3D3}, // R4 R2 p2
        {1'b1, 1'b0, 16'h0123, 16'h0000, 16'hFFFF, 16'h0000, 10'h3D3}, // R4 R2 p3
        {1'b1, 1'b0, 16'h011F, 16'h0000, 16'h1234, 16'h1234, 10'h3D3}, // R3 below window
        {1'b1, 1'b0, 16'h0128, 16'h0000, 16'hBEEF, 16'hBEEF, 10'h3D3}, // R3 above window
        {1'b1, 1'b1, 16'h0128, 16'h0000, 16'h7777, 16'h7777, 10'h3D3}, // R3 write above window
        {1'b0, 1'b1, 16'h0124, 16'h0000, 16'h4321, 16'h4321, 10'h3D3}, // R8 strobe low write
        {1'b0, 1'b0, 16'h0121, 16'h0000, 16'h9999, 16'h9999, 10'h3D3}, // R3 R8 strobe low read
        {1'b1, 1'b1, 16'h0121, 16'h0000, 16'h6666, 16'h6666, 10'h3D3}, // R7 write to probe
        {1'b1, 1'b1, 16'h0124, 16'h0000, 16'h2222, 16'h2222, 10'h3C0}, // R6 clear c0
        {1'b1, 1'b0, 16'h0124, 16'h0000, 16'h0F0F, 16'h0000, 10'h3C0}  // R5 read cleared c0
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic w, input logic [15:0] a,
                         input logic [15:0] wd, input logic [15:0] rd);
        @(negedge clk);
        up_valid = v; up_rw = w; up_addr = a; up_wdata = wd; up_rdata = rd;
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        probe_in = {1'b0, 10'h2C3, 7'h5A, 1'b1};
        #1;
        // R9 power-up state before any edge
        chk("R9 ctrl_out", 32'(ctrl_out), 32'h0);
        chk("R9 dn_valid", 32'(dn_valid), 32'h0);
        chk("R9 dn_rdata", 32'(dn_rdata), 32'h0);
        chk("R9 dn_addr",  32'(dn_addr),  32'h0);

        // R1 latency: strobe visible downstream one edge later, not before
        @(negedge clk);
        up_valid = 1'b1; up_addr = 16'h0033; up_wdata = 16'hC0DE; up_rw = 1'b1;
        #1;
        chk("R1 dn_valid before edge", 32'(dn_valid), 32'h0);
        @(posedge clk);
        #1;
        chk("R1 dn_valid after edge", 32'(dn_valid), 32'h1);
        chk("R1 dn_wdata after edge", 32'(dn_wdata), 32'hC0DE);
        chk("R3 ctrl untouched by miss write", 32'(ctrl_out), 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][75], VEC[i][74], VEC[i][73:58], VEC[i][57:42], VEC[i][41:26]);
            chk($sformatf("vector %0d dn_rdata (R3-R7 per row)", i), 32'(dn_rdata), 32'(VEC[i][25:10]));
            chk($sformatf("vector %0d ctrl_out", i), 32'(ctrl_out), 32'(VEC[i][9:0]));
            chk($sformatf("R1 vector %0d dn_addr", i), 32'(dn_addr), 32'(VEC[i][73:58]));
            chk($sformatf("R1 vector %0d dn_wdata", i), 32'(dn_wdata), 32'(VEC[i][57:42]));
            chk($sformatf("R1 vector %0d dn_rw", i), 32'(dn_rw), 32'(VEC[i][74]));
            chk($sformatf("R1 vector %0d dn_valid", i), 32'(dn_valid), 32'(VEC[i][75]));
        end

        // R4: live probe levels, widest probe at all ones
        probe_in = {1'b1, 10'h3FF, 7'h7F, 1'b0};
        drive(1'b1, 1'b0, 16'h0122, 16'h0000, 16'h0000);
        chk("R4 p2 all ones zero-extended", 32'(dn_rdata), 32'h03FF);
        drive(1'b1, 1'b0, 16'h0121, 16'h0000, 16'h0000);
        chk("R4 p1 all ones zero-extended", 32'(dn_rdata), 32'h007F);
        drive(1'b1, 1'b0, 16'h0123, 16'h0000, 16'h0000);
        chk("R4 p3 set", 32'(dn_rdata), 32'h0001);
        drive(1'b1, 1'b0, 16'h0120, 16'h0000, 16'h8000);
        chk("R4 p0 clear", 32'(dn_rdata), 32'h0000);

        // R8: strobe low across every control address, outputs keep their value
        for (int a = 4; a < 8; a++) begin
            drive(1'b0, 1'b1, 16'(BASE + a), 16'h0000, 16'h0000);
        end
        chk("R8 ctrl held with strobe low", 32'(ctrl_out), 32'h3C0);

        // R6 then R5: write c1 and read it back next cycle
        drive(1'b1, 1'b1, 16'h0125, 16'h0005, 16'h0000);
        chk("R6 c1 loaded", 32'(ctrl_out), 32'h3A0);
        drive(1'b1, 1'b0, 16'h0125, 16'h0000, 16'h0000);
        chk("R5 c1 read back", 32'(dn_rdata), 32'h0005);

        drive(1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000);
        finished = 1;
        summary();
    end

endmodule